// File: doc/BRIEF.md
# Two-Wire Master Transfer Sequencer

This block is the command engine of a two-wire serial controller in master mode. Software programs a control word and a byte count. The block then drives a bus model one byte at a time over a request/acknowledge handshake. The bus model carries out four operations: start with an address, send a byte, receive a byte, and stop. Bit-level line timing, slave operation and 10-bit addressing are not part of this block.

Two modes are supported. In counted mode the block moves exactly the programmed number of bytes. When the count runs out, it either ends the transfer with a stop, if one is pending, or it raises access-ready, drops master mode and keeps the bus. In repeat mode the count is not used. Transmit drains every byte the host has buffered, receive fills the receive buffer, and the transfer runs until the host asks for a stop. The block clears the start, stop and master command bits by itself. It reports a refused address or byte through a sticky not-acknowledged flag.

Top module: `tw_xfer_seq`

## Requirements
- R1: After synchronous reset the control word, the count register, the live count, both flags, `tx_ready`, `rx_ready`, `busy` and `bus_req` are all 0.
- R2: A control write stores only the bits set in 0xCF87. No bus operation follows a write unless it sets enable (bit 15), master (bit 10) and start (bit 0) and leaves bit 8 clear. A start bit that is not acted on clears itself.
- R3: An accepted start issues a START operation (`bus_cmd` 0) to `target_addr`. `bus_read` is the inverse of control bit 9. Both byte buffers are emptied and start (bit 0) clears.
- R4: A refused address sets `stat_nack`, clears stop (bit 1), moves no bytes and returns to idle without a STOP.
- R5: In counted mode (bit 2 clear), the live count `cur_count` is loaded from the count register when the address is accepted. It drops by one for each byte received, and for each byte sent that the bus accepts.
- R6: In counted mode, when the live count reaches 0 with stop set, the block issues a STOP operation (`bus_cmd` 3). It then clears stop, reloads the live count, empties the transmit buffer and goes idle with master still set.
- R7: In counted mode, when the live count reaches 0 with stop clear, the block sets `stat_ardy`, clears master (bit 10) and keeps the bus (`busy` high). A later control write with stop set issues the STOP.
- R8: In repeat mode (bit 2 set), a pending stop ends the transfer with a STOP operation before any further byte is moved.
- R9: In repeat transmit, every buffered byte is sent in push order as SEND operations (`bus_cmd` 1). The live count is left unchanged. `tx_ready` is high while the transmit buffer is empty.
- R10: In repeat receive, RECV operations (`bus_cmd` 2) continue until the receive buffer holds RX_DEPTH bytes and then pause. `rx_ready` is high while the buffer is full. One pop allows exactly one more RECV. In counted mode `rx_ready` is high while the buffer is not empty.
- R11: A refused data byte stops all further sending, sets `stat_nack`, clears stop and leaves the bus held. The refused byte is not counted.
- R12: In counted transmit, `tx_ready` is high only while bytes remain, no refusal has occurred and the transmit buffer is empty. It is low once the count reaches 0.
- R13: Exactly one byte moves per handshake. `bus_req` and `bus_cmd` hold until `bus_ack`, and `bus_req` is low in the cycle after an acknowledge.
- R14: `stat_nack` and `stat_ardy` are sticky and return to 0 only on `clr_nack` or `clr_ardy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write value |
| cnt_we | input | 1 | Count register write strobe |
| cnt_wdata | input | CNT_W | Count register write value |
| target_addr | input | ADDR_W | Slave address used by START |
| tx_push | input | 1 | Push one byte into the transmit buffer |
| tx_data | input | 8 | Byte to push |
| rx_pop | input | 1 | Pop the head of the receive buffer |
| clr_nack | input | 1 | Clear the not-acknowledged flag |
| clr_ardy | input | 1 | Clear the access-ready flag |
| ctl_q | output | 16 | Control word readback |
| cur_count | output | CNT_W | Live transfer count |
| stat_ardy | output | 1 | Access-ready flag |
| stat_nack | output | 1 | Not-acknowledged flag |
| tx_ready | output | 1 | Transmitter wants bytes |
| rx_ready | output | 1 | Received bytes available |
| rx_data | output | 8 | Head of the receive buffer |
| busy | output | 1 | Bus owned by this block |
| bus_req | output | 1 | Bus operation request |
| bus_cmd | output | 2 | Operation: 0 START, 1 SEND, 2 RECV, 3 STOP |
| bus_addr | output | ADDR_W | Address for START |
| bus_read | output | 1 | START direction, 1 for read |
| bus_wdata | output | 8 | Byte for SEND |
| bus_ack | input | 1 | Operation done |
| bus_nack | input | 1 | Refusal, valid with bus_ack |
| bus_rdata | input | 8 | Received byte, valid with bus_ack |

## Verification
A sequencer stuck in the wrong state appears at the bus port within one handshake. It shows up as a missing or extra START, SEND, RECV or STOP in the logged operation stream, or as a request that does not drop after its acknowledge. A wrong live count shows up as a transfer that moves the wrong number of bytes before the stop or access-ready decision. It is also visible directly on `cur_count` in the cycle after each acknowledge. A self-clear that fails leaves a stop, start or master bit visible on `ctl_q`. A stop bit left set would end the next transfer early.

// File: rtl/tw_xfer_pkg.sv
package tw_xfer_pkg;
  localparam int BYTE_W = 8;

  // control word bit positions (software decodes these)
  localparam int CB_EN   = 15;
  localparam int CB_MST  = 10;
  localparam int CB_TX   = 9;
  localparam int CB_WIDE = 8;
  localparam int CB_RPT  = 2;
  localparam int CB_STP  = 1;
  localparam int CB_STT  = 0;
  localparam logic [15:0] CTL_KEEP = 16'hCF87;

  typedef enum logic [1:0] {
    BUS_START = 2'd0,
    BUS_SEND  = 2'd1,
    BUS_RECV  = 2'd2,
    BUS_STOP  = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_XFER = 3'd2,
    ST_STOP = 3'd3,
    ST_HOLD = 3'd4
  } seq_state_e;
endpackage

// File: rtl/tw_byte_fifo.sv
module tw_byte_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] lvl;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push & (lvl != LW'(DEPTH));
  assign do_pop  = pop & (lvl != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   lvl <= lvl + 1'b1;
        2'b01:   lvl <= lvl - 1'b1;
        default: lvl <= lvl;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (lvl == '0);
  assign full  = (lvl == LW'(DEPTH));
endmodule

// File: rtl/tw_ctl_regs.sv
module tw_ctl_regs import tw_xfer_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [15:0]      ctl_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             clr_start,
  input  logic             clr_stop,
  input  logic             clr_master,
  output logic [15:0]      ctl_q,
  output logic [CNT_W-1:0] cnt_q
);
  logic [15:0] ctl_nx;

  // host write first, then the sequencer's self-clears on top of it
  always_comb begin
    ctl_nx = ctl_we ? (ctl_wdata & CTL_KEEP) : ctl_q;
    if (clr_start)  ctl_nx[CB_STT] = 1'b0;
    if (clr_stop)   ctl_nx[CB_STP] = 1'b0;
    if (clr_master) ctl_nx[CB_MST] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      cnt_q <= '0;
    end else begin
      ctl_q <= ctl_nx;
      if (cnt_we) cnt_q <= cnt_wdata;
    end
  end
endmodule

// File: rtl/tw_seq_fsm.sv
module tw_seq_fsm import tw_xfer_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       ctl_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic              clr_nack,
  input  logic              clr_ardy,
  input  logic              tx_empty,
  input  logic [BYTE_W-1:0] tx_head,
  input  logic              rx_full,
  input  logic              rx_empty,
  input  logic              bus_ack,
  input  logic              bus_nack,
  output logic              tx_pop,
  output logic              rx_push,
  output logic              flush_tx,
  output logic              flush_rx,
  output logic              clr_start,
  output logic              clr_stop,
  output logic              clr_master,
  output logic [CNT_W-1:0]  cur_count,
  output logic              stat_ardy,
  output logic              stat_nack,
  output logic              tx_ready,
  output logic              rx_ready,
  output logic              busy,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_read,
  output logic [BYTE_W-1:0] bus_wdata
);
  seq_state_e        st_q, st_d;
  bus_cmd_e          cmd_q, cmd_d;
  logic              req_q, req_d;
  logic              dir_q, dir_d;      // 1 = transmit
  logic              rd_q, rd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] wdat_q, wdat_d;
  logic [CNT_W-1:0]  cur_q, cur_d;
  logic              ardy_q, ardy_d, nack_q, nack_d;
  logic              txr_q, txr_d, rxr_q, rxr_d;
  logic              go, rpt, stp;
  logic              unused_ctl;

  assign unused_ctl = ^{ctl_q[14:11], ctl_q[7:3]};
  assign go  = ctl_q[CB_EN] & ctl_q[CB_MST] & ctl_q[CB_STT] & ~ctl_q[CB_WIDE];
  assign rpt = ctl_q[CB_RPT];
  assign stp = ctl_q[CB_STP];

  always_comb begin
    st_d = st_q;  cmd_d = cmd_q;  req_d = req_q;  dir_d = dir_q;
    rd_d = rd_q;  addr_d = addr_q; wdat_d = wdat_q; cur_d = cur_q;
    ardy_d = ardy_q & ~clr_ardy;
    nack_d = nack_q & ~clr_nack;
    tx_pop = 1'b0; rx_push = 1'b0; flush_tx = 1'b0; flush_rx = 1'b0;
    clr_start = 1'b0; clr_stop = 1'b0; clr_master = 1'b0;

    case (st_q)
      ST_IDLE, ST_HOLD: begin
        if (st_q == ST_HOLD && stp) begin
          st_d = ST_STOP; req_d = 1'b1; cmd_d = BUS_STOP;
        end else if (ctl_q[CB_STT]) begin
          clr_start = 1'b1;
          if (go) begin
            st_d     = ST_ADDR;
            req_d    = 1'b1;
            cmd_d    = BUS_START;
            dir_d    = ctl_q[CB_TX];
            rd_d     = ~ctl_q[CB_TX];
            addr_d   = target_addr;
            flush_tx = 1'b1;
            flush_rx = 1'b1;
          end
        end
      end

      ST_ADDR: begin
        if (bus_ack) begin
          req_d = 1'b0;
          if (bus_nack) begin
            nack_d   = 1'b1;
            clr_stop = 1'b1;
            st_d     = ST_IDLE;
          end else begin
            cur_d = cnt_q;
            st_d  = ST_XFER;
          end
        end
      end

      ST_XFER: begin
        if (req_q) begin
          if (bus_ack) begin
            req_d = 1'b0;
            if (cmd_q == BUS_SEND && bus_nack) begin
              nack_d   = 1'b1;
              clr_stop = 1'b1;
              st_d     = ST_HOLD;
            end else begin
              if (cmd_q == BUS_RECV) rx_push = 1'b1;
              if (!rpt) cur_d = cur_q - 1'b1;
            end
          end
        end else if (rpt && stp) begin
          st_d = ST_STOP; req_d = 1'b1; cmd_d = BUS_STOP;
        end else if (!rpt && cur_q == '0) begin
          if (stp) begin
            st_d = ST_STOP; req_d = 1'b1; cmd_d = BUS_STOP;
          end else begin
            ardy_d     = 1'b1;
            clr_master = 1'b1;
            st_d       = ST_HOLD;
          end
        end else if (dir_q) begin
          if (!tx_empty) begin
            tx_pop = 1'b1;
            req_d  = 1'b1;
            cmd_d  = BUS_SEND;
            wdat_d = tx_head;
          end
        end else if (!rx_full) begin
          req_d = 1'b1;
          cmd_d = BUS_RECV;
        end
      end

      ST_STOP: begin
        if (bus_ack) begin
          req_d    = 1'b0;
          clr_stop = 1'b1;
          cur_d    = cnt_q;
          flush_tx = 1'b1;
          st_d     = ST_IDLE;
        end
      end

      default: st_d = ST_IDLE;
    endcase

    txr_d = (st_q == ST_XFER) & dir_q & ~req_q & tx_empty & (rpt | (cur_q != '0));
    rxr_d = rpt ? rx_full : ~rx_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cmd_q  <= BUS_START;
      req_q  <= 1'b0;
      dir_q  <= 1'b0;
      rd_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      cur_q  <= '0;
      ardy_q <= 1'b0;
      nack_q <= 1'b0;
      txr_q  <= 1'b0;
      rxr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      req_q  <= req_d;
      dir_q  <= dir_d;
      rd_q   <= rd_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
      cur_q  <= cur_d;
      ardy_q <= ardy_d;
      nack_q <= nack_d;
      txr_q  <= txr_d;
      rxr_q  <= rxr_d;
    end
  end

  assign cur_count = cur_q;
  assign stat_ardy = ardy_q;
  assign stat_nack = nack_q;
  assign tx_ready  = txr_q;
  assign rx_ready  = rxr_q;
  assign busy      = (st_q != ST_IDLE);
  assign bus_req   = req_q;
  assign bus_cmd   = cmd_q;
  assign bus_addr  = addr_q;
  assign bus_read  = rd_q;
  assign bus_wdata = wdat_q;
endmodule

// File: rtl/tw_xfer_seq.sv
module tw_xfer_seq import tw_xfer_pkg::*; #(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 7,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [15:0]       ctl_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic              tx_push,
  input  logic [7:0]        tx_data,
  input  logic              rx_pop,
  input  logic              clr_nack,
  input  logic              clr_ardy,
  output logic [15:0]       ctl_q,
  output logic [CNT_W-1:0]  cur_count,
  output logic              stat_ardy,
  output logic              stat_nack,
  output logic              tx_ready,
  output logic              rx_ready,
  output logic [7:0]        rx_data,
  output logic              busy,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_read,
  output logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_nack,
  input  logic [7:0]        bus_rdata
);
  logic [CNT_W-1:0]  cnt_q;
  logic              clr_start, clr_stop, clr_master;
  logic              tx_pop, rx_push, flush_tx, flush_rx;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [BYTE_W-1:0] tx_head;
  logic              unused_txfull;

  assign unused_txfull = tx_full;

  tw_ctl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk, .rst, .ctl_we, .ctl_wdata, .cnt_we, .cnt_wdata,
    .clr_start, .clr_stop, .clr_master, .ctl_q, .cnt_q
  );

  tw_byte_fifo #(.DEPTH(TX_DEPTH), .W(BYTE_W)) u_txbuf (
    .clk, .rst, .flush(flush_tx), .push(tx_push), .din(tx_data),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  tw_byte_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) u_rxbuf (
    .clk, .rst, .flush(flush_rx), .push(rx_push), .din(bus_rdata),
    .pop(rx_pop), .dout(rx_data), .empty(rx_empty), .full(rx_full)
  );

  tw_seq_fsm #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk, .rst, .ctl_q, .cnt_q, .target_addr, .clr_nack, .clr_ardy,
    .tx_empty, .tx_head, .rx_full, .rx_empty, .bus_ack, .bus_nack,
    .tx_pop, .rx_push, .flush_tx, .flush_rx,
    .clr_start, .clr_stop, .clr_master,
    .cur_count, .stat_ardy, .stat_nack, .tx_ready, .rx_ready, .busy,
    .bus_req, .bus_cmd, .bus_addr, .bus_read, .bus_wdata
  );
endmodule

// File: rtl/tw_xfer_seq_chk.sv
module tw_xfer_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_req,
  input logic             bus_ack,
  input logic             bus_nack,
  input logic [1:0]       bus_cmd,
  input logic [15:0]      ctl_q,
  input logic [CNT_W-1:0] cur_count,
  input logic             stat_ardy,
  input logic             stat_nack,
  input logic             tx_ready,
  input logic             busy
);
  // R1: nothing requested and control word clear right after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_req && ctl_q == 16'h0000));

  // R13: a request and its command hold until acknowledged
  p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_cmd)));

  // R13: one operation per handshake
  p_req_drop_r13: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack) |=> !bus_req);

  // R5: an accepted byte in counted mode lowers the live count by one
  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack && !ctl_q[2] &&
     (bus_cmd == 2'd2 || (bus_cmd == 2'd1 && !bus_nack)))
    |=> (cur_count == $past(cur_count) - 1'b1));

  // R11 / R4: a refusal leaves no stop pending
  p_nack_stop_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_nack) |-> !ctl_q[1]);

  // R7: access-ready comes with master dropped
  p_ardy_master_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_ardy) |-> !ctl_q[10]);

  // R12: transmit ready only while the bus is owned
  p_txrdy_busy_r12: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> busy);
endmodule

bind tw_xfer_seq tw_xfer_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_ack(bus_ack),
  .bus_nack(bus_nack), .bus_cmd(bus_cmd), .ctl_q(ctl_q),
  .cur_count(cur_count), .stat_ardy(stat_ardy), .stat_nack(stat_nack),
  .tx_ready(tx_ready), .busy(busy)
);

// File: tb/tb_tw_xfer_seq.sv
`timescale 1ns/1ps
module tb_tw_xfer_seq;
  localparam logic [15:0] EN  = 16'h8000;
  localparam logic [15:0] MST = 16'h0400;
  localparam logic [15:0] TXB = 16'h0200;
  localparam logic [15:0] RPT = 16'h0004;
  localparam logic [15:0] STP = 16'h0002;
  localparam logic [15:0] STT = 16'h0001;
  localparam logic [7:0]  RX_BASE = 8'h30;

  // stimulus/expectation table: [6] dir tx, [5] stop, [4] expect ardy, [3:0] count
  localparam int NV = 6;
  localparam logic [6:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 4'd3},
    {1'b0, 1'b1, 1'b0, 4'd2},
    {1'b1, 1'b0, 1'b1, 4'd2},
    {1'b0, 1'b0, 1'b1, 4'd4},
    {1'b1, 1'b1, 1'b0, 4'd1},
    {1'b0, 1'b0, 1'b1, 4'd0}
  };

  logic clk = 0, rst = 1;
  logic ctl_we = 0, cnt_we = 0, tx_push = 0, rx_pop = 0, clr_nack = 0, clr_ardy = 0;
  logic [15:0] ctl_wdata = '0, cnt_wdata = '0;
  logic [6:0]  target_addr = 7'h52;
  logic [7:0]  tx_data = '0;
  logic [15:0] ctl_q, cur_count;
  logic stat_ardy, stat_nack, tx_ready, rx_ready, busy, bus_req, bus_read;
  logic [1:0] bus_cmd;
  logic [6:0] bus_addr;
  logic [7:0] rx_data, bus_wdata;
  logic bus_ack = 0, bus_nack = 0;
  logic [7:0] bus_rdata = '0;

  int n_chk = 0, n_fail = 0;
  int n_start = 0, n_send = 0, n_recv = 0, n_stop = 0;
  int nack_idx = -1;
  logic nack_addr = 0;
  logic [6:0] last_addr;
  logic last_read;
  logic [7:0] sent_log [256];
  bit done = 0;

  always #2.5 clk = ~clk;

  tw_xfer_seq dut (
    .clk, .rst, .ctl_we, .ctl_wdata, .cnt_we, .cnt_wdata, .target_addr,
    .tx_push, .tx_data, .rx_pop, .clr_nack, .clr_ardy, .ctl_q, .cur_count,
    .stat_ardy, .stat_nack, .tx_ready, .rx_ready, .rx_data, .busy,
    .bus_req, .bus_cmd, .bus_addr, .bus_read, .bus_wdata,
    .bus_ack, .bus_nack, .bus_rdata
  );

  // bus model: acknowledges each request half a cycle after it appears
  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 0; bus_nack = 0;
    end else if (bus_req && !bus_ack) begin
      bus_ack = 1;
      case (bus_cmd)
        2'd0: begin n_start++; bus_nack = nack_addr; last_addr = bus_addr; last_read = bus_read; end
        2'd1: begin sent_log[n_send[7:0]] = bus_wdata; bus_nack = (n_send == nack_idx); n_send++; end
        2'd2: begin bus_rdata = RX_BASE + n_recv[7:0]; bus_nack = 0; n_recv++; end
        default: begin bus_nack = 0; n_stop++; end
      endcase
    end else begin
      bus_ack = 0; bus_nack = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    @(negedge clk); cnt_we = 1; cnt_wdata = v;
    @(negedge clk); cnt_we = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); tx_push = 1; tx_data = b;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic pop;
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic clear_flags;
    @(negedge clk); clr_nack = 1; clr_ardy = 1;
    @(negedge clk); clr_nack = 0; clr_ardy = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int s0, r0, p0, q0;
    repeat (5) @(negedge clk);
    rst = 0;
    idle(1);
    // R1 reset state
    chk("R1 ctl", ctl_q, 0);
    chk("R1 count", cur_count, 0);
    chk("R1 flags", {stat_ardy, stat_nack, tx_ready, rx_ready}, 0);
    chk("R1 bus", {busy, bus_req}, 0);

    // table walk: counted transfers
    for (int e = 0; e < NV; e++) begin
      logic tx, sp, ea;
      int cnt;
      tx = VEC[e][6]; sp = VEC[e][5]; ea = VEC[e][4]; cnt = int'(VEC[e][3:0]);
      clear_flags();
      s0 = n_send; r0 = n_recv; p0 = n_stop; q0 = n_start;
      wr_cnt(16'(cnt));
      wr_ctl(EN | MST | (tx ? TXB : 16'h0) | (sp ? STP : 16'h0) | STT);
      idle(3);
      if (tx) for (int i = 0; i < cnt; i++) push(8'hA0 + 8'(16 * e + i));
      idle(40);
      chk("R3 start issued", n_start - q0, 1);
      chk("R3 address", last_addr, 7'h52);
      chk("R3 direction", last_read, !tx);
      chk("R3 start bit cleared", ctl_q[0], 0);
      chk("R5 bytes moved", tx ? (n_send - s0) : (n_recv - r0), cnt);
      chk("R6/R7 live count", cur_count, sp ? cnt : 0);
      chk("R7 ardy", stat_ardy, ea);
      chk("R6/R7 master bit", ctl_q[10], sp);
      chk("R6 stop bit cleared", ctl_q[1], 0);
      chk("R6 stop issued", n_stop - p0, sp);
      chk("R7 bus held", busy, !sp);
      if (tx) begin
        for (int i = 0; i < cnt; i++)
          chk("R13 sent byte", sent_log[8'(s0 + i)], 8'hA0 + 8'(16 * e + i));
        chk("R12 tx_ready low at zero", tx_ready, 0);
      end else begin
        chk("R10 counted rx_ready", rx_ready, cnt != 0);
        for (int i = 0; i < cnt; i++) begin
          chk("R10 received byte", rx_data, RX_BASE + 8'(r0 + i));
          pop();
        end
      end
      if (!sp) begin
        idle(5);
        chk("R14 ardy sticky", stat_ardy, 1);
        wr_ctl(EN | STP);
        idle(10);
        chk("R7 later stop issued", n_stop - p0, 1);
        chk("R7 idle after stop", busy, 0);
        chk("R6 count reloaded", cur_count, cnt);
      end
    end

    // R2: masking and no transfer without enable or master
    clear_flags();
    q0 = n_start;
    wr_ctl(16'h7FFE);
    idle(3);
    chk("R2 mask readback", ctl_q, 16'h4F86);
    wr_ctl(16'h7FFF);
    idle(5);
    chk("R2 no start without enable", n_start - q0, 0);
    chk("R2 unused start clears", ctl_q[0], 0);
    wr_ctl(EN | STT);
    idle(5);
    chk("R2 no start without master", n_start - q0, 0);
    chk("R2 idle", busy, 0);
    wr_ctl(16'h0000);

    // R4: refused address
    nack_addr = 1;
    s0 = n_send; p0 = n_stop;
    wr_cnt(16'd2);
    wr_ctl(EN | MST | TXB | STP | STT);
    idle(10);
    nack_addr = 0;
    chk("R4 nack set", stat_nack, 1);
    chk("R4 stop cleared", ctl_q[1], 0);
    chk("R4 idle without stop", {busy, 8'(n_stop - p0)}, 0);
    chk("R4 no bytes", n_send - s0, 0);
    idle(5);
    chk("R14 nack sticky", stat_nack, 1);
    clear_flags();
    chk("R14 nack cleared", stat_nack, 0);

    // R12: counted transmit waiting for data
    wr_cnt(16'd2);
    wr_ctl(EN | MST | TXB | STT);
    idle(8);
    chk("R12 tx_ready while bytes remain", tx_ready, 1);
    push(8'h11); push(8'h22);
    idle(15);
    chk("R12 tx_ready low after count", tx_ready, 0);
    chk("R7 ardy after counted tx", stat_ardy, 1);
    wr_ctl(EN | STP);
    idle(10);
    clear_flags();

    // R11: refused data byte
    s0 = n_send; p0 = n_stop;
    nack_idx = n_send + 1;
    wr_cnt(16'd4);
    wr_ctl(EN | MST | TXB | STP | STT);
    idle(3);
    push(8'h51); push(8'h52); push(8'h53); push(8'h54);
    idle(20);
    nack_idx = -1;
    chk("R11 sending halted", n_send - s0, 2);
    chk("R11 nack set", stat_nack, 1);
    chk("R11 stop cleared", ctl_q[1], 0);
    chk("R11 refused byte not counted", cur_count, 3);
    chk("R11 bus held", {busy, tx_ready}, 2'b10);
    chk("R11 no stop yet", n_stop - p0, 0);
    wr_ctl(EN | STP);
    idle(10);
    chk("R11 closed by stop", {busy, 8'(n_stop - p0)}, 1);
    chk("R6 reload after stop", cur_count, 4);
    clear_flags();

    // R9 / R8: repeat transmit
    s0 = n_send; p0 = n_stop;
    wr_cnt(16'd5);
    wr_ctl(EN | MST | TXB | RPT | STT);
    idle(3);
    push(8'hC1); push(8'hC2); push(8'hC3);
    idle(20);
    chk("R9 all sent", n_send - s0, 3);
    for (int i = 0; i < 3; i++) chk("R9 order", sent_log[8'(s0 + i)], 8'hC1 + 8'(i));
    chk("R9 count untouched", cur_count, 5);
    chk("R9 tx_ready", {tx_ready, busy}, 2'b11);
    wr_ctl(EN | MST | TXB | RPT | STP);
    idle(10);
    chk("R8 stop issued", n_stop - p0, 1);
    chk("R8 idle, stop clear", {busy, ctl_q[1]}, 0);
    chk("R8 no extra bytes", n_send - s0, 3);

    // R10 / R8: repeat receive
    r0 = n_recv; p0 = n_stop;
    wr_ctl(EN | MST | RPT | STT);
    idle(30);
    chk("R10 fill to depth", n_recv - r0, 4);
    chk("R10 rx_ready full", rx_ready, 1);
    chk("R10 head byte", rx_data, RX_BASE + 8'(r0));
    pop();
    idle(10);
    chk("R10 one more after pop", n_recv - r0, 5);
    chk("R10 head advanced", rx_data, RX_BASE + 8'(r0 + 1));
    wr_ctl(EN | MST | RPT | STP);
    idle(10);
    chk("R8 repeat rx stop", n_stop - p0, 1);
    chk("R8 repeat rx idle", busy, 0);
    chk("R8 no receive after stop", n_recv - r0, 5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule